// File: doc/BRIEF.md
# Eight-Input Fixed-Priority Interrupt Controller

This block collects up to eight interrupt request lines, ranks them by a fixed priority and raises a single interrupt output toward a processor. Software talks to it through a byte-wide register interface with one address bit. Address 0 is the command port. Address 1 is the data port. The processor answers an interrupt with a one-cycle acknowledge strobe. The controller then places a vector byte on the read-data output and records the granted level as in service.

Before it raises any interrupt, the controller must be programmed through a short start-up sequence. That sequence sets the vector base, the cascade wiring and the end-of-interrupt style. A level leaves the in-service state in one of three ways: a command that names the level, a command that clears the most urgent active level, or automatically at acknowledge when auto-clear was selected. A request that vanishes before the acknowledge is answered with the vector of the lowest-priority input. The in-service state is left untouched in that case, so software can see that the interrupt was false.

Top module: `prog_irq_ctrl`

## Requirements
- R1: While `rst` is high at a clock edge, and after it, `rdata`, `int_out`, `casc_map`, `slave_id`, the request, in-service and mask registers all read zero, and command-port reads select the request register.
- R2: A command-port write with bit 4 set starts the start-up sequence. Its bit 1 set means single mode, which skips word 3. Its bit 0 set means word 4 follows. The next data-port writes are taken as word 2, word 3 and word 4 in that order. The start clears the request, in-service and mask registers and selects the request register for reads. `int_out` stays low, and `ack` has no effect, until the sequence has completed.
- R3: The vector is bits 7..3 of word 2 followed by the 3-bit index of the granted input, for example 0x20..0x27 for a base of 0x20.
- R4: Once set up in cascade mode, `casc_map` shows word 3 when `master_mode` is 1, and `slave_id` shows word 3 bits 2..0 when `master_mode` is 0. The output that does not apply, and both outputs in single mode, read zero.
- R5: Once the sequence has ended, a data-port write loads the mask, where a 1 disables that input. A data-port read returns the mask one cycle later.
- R6: A request bit is set by a rising edge on its line and is cleared when the line is low at a clock edge or when that input is acknowledged. A line held high does not request again.
- R7: Input 0 has the highest priority. An input is eligible when it is requested, unmasked, and no in-service bit is set at its own level or a higher one. `int_out` rises one cycle after the request register shows an eligible input.
- R8: On `ack`, the winning input's in-service bit is set, the vector appears on `rdata` after that clock edge, and `int_out` is low in the following cycle.
- R9: When word 4 bit 1 is set (auto-clear), an acknowledge leaves the in-service register unchanged.
- R10: Command byte 0x0A makes later command-port reads return the request register. Command byte 0x0B makes them return the in-service register.
- R11: Command byte 0x60+L clears only in-service bit L.
- R12: Command byte 0x20 clears the highest-priority (lowest-index) in-service bit.
- R13: An acknowledge with no eligible input returns base+7 and leaves the in-service register unchanged, even when input 7 is masked.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| master_mode | input | 1 | 1 = master in a cascade, 0 = slave |
| irq_in | input | 8 | Interrupt request lines, index 0 highest priority |
| wr_en | input | 1 | Register write strobe |
| rd_en | input | 1 | Register read strobe |
| addr | input | 1 | 0 = command port, 1 = data port |
| wdata | input | 8 | Write data |
| ack | input | 1 | Interrupt acknowledge strobe, one cycle |
| rdata | output | 8 | Registered read data or vector |
| int_out | output | 1 | Interrupt request to the processor |
| casc_map | output | 8 | Inputs that carry a slave (master only) |
| slave_id | output | 3 | Cascade identity (slave only) |

## Verification
A single request line checks the vector, the in-service bookkeeping and the end-of-interrupt commands. Two simultaneous requests, followed by a higher one arriving while a lower one is in service, separate fixed-priority selection from nesting and from the blocking of lower levels. A masked line, a line held high after service, and a line dropped before acknowledge tell masking, edge detection and spurious handling apart. Master, slave, auto-clear and single-mode set-ups show that each start-up word lands in the right field.

// File: rtl/pic_pkg.sv
package pic_pkg;
  typedef enum logic [1:0] {
    SEQ_RUN  = 2'd0,
    SEQ_BASE = 2'd1,
    SEQ_CASC = 2'd2,
    SEQ_MODE = 2'd3
  } seq_t;

  localparam int CMD_START_BIT = 4;
  localparam int CMD_RSEL_BIT  = 3;
  localparam logic [2:0] EOI_LOWEST = 3'b001;
  localparam logic [2:0] EOI_NAMED  = 3'b011;
endpackage

// File: rtl/pic_cfg.sv
module pic_cfg #(
  parameter int N_IN = 8,
  parameter int DW   = 8,
  localparam int IDW = $clog2(N_IN)
) (
  input  logic                clk,
  input  logic                rst,
  input  logic                init_go,
  input  logic                dat_wr,
  input  logic [DW-1:0]       wdata,
  output logic                ready,
  output logic [DW-IDW-1:0]   base,
  output logic                aeoi,
  output logic                single,
  output logic [N_IN-1:0]     casc_word,
  output logic [N_IN-1:0]     mask
);
  import pic_pkg::*;

  seq_t seq_q;
  logic want4_q;

  always_ff @(posedge clk) begin
    if (rst) begin
      seq_q     <= SEQ_RUN;
      ready     <= 1'b0;
      base      <= '0;
      aeoi      <= 1'b0;
      single    <= 1'b0;
      want4_q   <= 1'b0;
      casc_word <= '0;
      mask      <= '0;
    end else if (init_go) begin
      seq_q     <= SEQ_BASE;
      ready     <= 1'b0;
      single    <= wdata[1];
      want4_q   <= wdata[0];
      aeoi      <= 1'b0;
      casc_word <= '0;
      mask      <= '0;
    end else if (dat_wr) begin
      case (seq_q)
        SEQ_RUN: mask <= wdata[N_IN-1:0];
        SEQ_BASE: begin
          base <= wdata[DW-1:IDW];
          if (!single)     seq_q <= SEQ_CASC;
          else if (want4_q) seq_q <= SEQ_MODE;
          else begin
            seq_q <= SEQ_RUN;
            ready <= 1'b1;
          end
        end
        SEQ_CASC: begin
          casc_word <= wdata[N_IN-1:0];
          if (want4_q) seq_q <= SEQ_MODE;
          else begin
            seq_q <= SEQ_RUN;
            ready <= 1'b1;
          end
        end
        default: begin
          aeoi  <= wdata[1];
          seq_q <= SEQ_RUN;
          ready <= 1'b1;
        end
      endcase
    end
  end
endmodule

// File: rtl/pic_req.sv
module pic_req #(
  parameter int N_IN = 8
) (
  input  logic            clk,
  input  logic            rst,
  input  logic            clr,
  input  logic [N_IN-1:0] line,
  input  logic [N_IN-1:0] take,
  output logic [N_IN-1:0] irr
);
  logic [N_IN-1:0] line_q;
  logic [N_IN-1:0] rise;

  assign rise = line & ~line_q;

  always_ff @(posedge clk) begin
    if (rst) begin
      line_q <= '0;
      irr    <= '0;
    end else begin
      line_q <= line;
      if (clr) irr <= '0;
      else     irr <= (irr | rise) & line & ~take;
    end
  end
endmodule

// File: rtl/pic_isr.sv
module pic_isr #(
  parameter int N_IN = 8,
  localparam int IDW = $clog2(N_IN)
) (
  input  logic            clk,
  input  logic            rst,
  input  logic            clr,
  input  logic [N_IN-1:0] set_vec,
  input  logic            named_go,
  input  logic [IDW-1:0]  named_lvl,
  input  logic            lowest_go,
  output logic [N_IN-1:0] isr
);
  logic [N_IN-1:0] nxt;
  logic [N_IN-1:0] low_bit;

  assign low_bit = isr & (~isr + N_IN'(1));

  always_comb begin
    nxt = isr;
    if (named_go)  nxt[named_lvl] = 1'b0;
    if (lowest_go) nxt = nxt & ~low_bit;
    nxt = nxt | set_vec;
  end

  always_ff @(posedge clk) begin
    if (rst || clr) isr <= '0;
    else            isr <= nxt;
  end
endmodule

// File: rtl/pic_prio.sv
module pic_prio #(
  parameter int N_IN = 8,
  localparam int IDW = $clog2(N_IN)
) (
  input  logic [N_IN-1:0] irr,
  input  logic [N_IN-1:0] mask,
  input  logic [N_IN-1:0] isr,
  output logic            win_vld,
  output logic [IDW-1:0]  win_idx
);
  logic [N_IN-1:0] blocked;
  logic [N_IN-1:0] elig;

  assign blocked[0] = isr[0];
  for (genvar g = 1; g < N_IN; g++) begin : g_blk
    assign blocked[g] = blocked[g-1] | isr[g];
  end

  assign elig    = irr & ~mask & ~blocked;
  assign win_vld = |elig;

  always_comb begin
    win_idx = '0;
    for (int i = N_IN - 1; i >= 0; i--) begin
      if (elig[i]) win_idx = IDW'(i);
    end
  end
endmodule

// File: rtl/prog_irq_ctrl.sv
module prog_irq_ctrl #(
  parameter int N_IN = 8,
  parameter int DW   = 8,
  localparam int IDW = $clog2(N_IN)
) (
  input  logic            clk,
  input  logic            rst,
  input  logic            master_mode,
  input  logic [N_IN-1:0] irq_in,
  input  logic            wr_en,
  input  logic            rd_en,
  input  logic            addr,
  input  logic [DW-1:0]   wdata,
  input  logic            ack,
  output logic [DW-1:0]   rdata,
  output logic            int_out,
  output logic [N_IN-1:0] casc_map,
  output logic [IDW-1:0]  slave_id
);
  import pic_pkg::*;

  logic cmd_wr, dat_wr, init_go, rsel_wr, eoi_wr, named_go, lowest_go;
  logic ready_q, aeoi_q, single_q, sel_isr_q, ack_fire;
  logic [DW-IDW-1:0] base_q;
  logic [N_IN-1:0]   casc_word, mask_q, irr_q, isr_q, take, set_vec;
  logic              win_vld;
  logic [IDW-1:0]    win_idx;

  assign cmd_wr    = wr_en & ~addr;
  assign dat_wr    = wr_en & addr;
  assign init_go   = cmd_wr & wdata[CMD_START_BIT];
  assign rsel_wr   = cmd_wr & ~wdata[CMD_START_BIT] & wdata[CMD_RSEL_BIT];
  assign eoi_wr    = cmd_wr & ~wdata[CMD_START_BIT] & ~wdata[CMD_RSEL_BIT];
  assign named_go  = eoi_wr & (wdata[DW-1:DW-3] == EOI_NAMED);
  assign lowest_go = eoi_wr & (wdata[DW-1:DW-3] == EOI_LOWEST);
  assign ack_fire  = ack & ready_q;

  always_comb begin
    take = '0;
    if (ack_fire && win_vld) take[win_idx] = 1'b1;
  end
  assign set_vec = aeoi_q ? '0 : take;

  pic_cfg #(.N_IN(N_IN), .DW(DW)) u_cfg (
    .clk(clk), .rst(rst), .init_go(init_go), .dat_wr(dat_wr), .wdata(wdata),
    .ready(ready_q), .base(base_q), .aeoi(aeoi_q), .single(single_q),
    .casc_word(casc_word), .mask(mask_q)
  );

  pic_req #(.N_IN(N_IN)) u_req (
    .clk(clk), .rst(rst), .clr(init_go), .line(irq_in), .take(take), .irr(irr_q)
  );

  pic_isr #(.N_IN(N_IN)) u_isr (
    .clk(clk), .rst(rst), .clr(init_go), .set_vec(set_vec),
    .named_go(named_go), .named_lvl(wdata[IDW-1:0]), .lowest_go(lowest_go),
    .isr(isr_q)
  );

  pic_prio #(.N_IN(N_IN)) u_prio (
    .irr(irr_q), .mask(mask_q), .isr(isr_q), .win_vld(win_vld), .win_idx(win_idx)
  );

  always_ff @(posedge clk) begin
    if (rst) begin
      sel_isr_q <= 1'b0;
      rdata     <= '0;
      int_out   <= 1'b0;
      casc_map  <= '0;
      slave_id  <= '0;
    end else begin
      if (init_go)      sel_isr_q <= 1'b0;
      else if (rsel_wr && wdata[1]) sel_isr_q <= wdata[0];

      if (ack_fire)
        rdata <= {base_q, (win_vld ? win_idx : IDW'(N_IN - 1))};
      else if (rd_en) begin
        if (addr)           rdata <= DW'(mask_q);
        else if (sel_isr_q) rdata <= DW'(isr_q);
        else                rdata <= DW'(irr_q);
      end

      int_out  <= ready_q & win_vld & ~ack_fire & ~init_go;
      casc_map <= (ready_q && master_mode && !single_q) ? casc_word : '0;
      slave_id <= (ready_q && !master_mode && !single_q) ? casc_word[IDW-1:0] : '0;
    end
  end
endmodule

// File: rtl/pic_chk.sv
module pic_chk #(
  parameter int N_IN = 8,
  parameter int DW   = 8,
  localparam int IDW = $clog2(N_IN)
) (
  input logic              clk,
  input logic              rst,
  input logic              wr_en,
  input logic              addr,
  input logic [DW-1:0]     wdata,
  input logic              ack,
  input logic [N_IN-1:0]   irq_in,
  input logic [DW-1:0]     rdata,
  input logic              int_out,
  input logic [N_IN-1:0]   isr,
  input logic [N_IN-1:0]   irr,
  input logic [N_IN-1:0]   mask,
  input logic              ready,
  input logic              aeoi,
  input logic              win_vld,
  input logic [IDW-1:0]    win_idx,
  input logic [DW-IDW-1:0] base
);
  p_init_clears_r2: assert property (@(posedge clk) disable iff (rst)
    (wr_en && !addr && wdata[4]) |=> (isr == '0 && irr == '0 && mask == '0 && !ready));

  p_int_needs_ready_r2: assert property (@(posedge clk) disable iff (rst)
    int_out |-> $past(ready));

  p_vector_base_r3: assert property (@(posedge clk) disable iff (rst)
    (ack && ready) |=> (rdata[DW-1:IDW] == $past(base)));

  p_irr_follows_line_r6: assert property (@(posedge clk) disable iff (rst)
    ((irr & ~$past(irq_in)) == '0));

  p_ack_sets_isr_r8: assert property (@(posedge clk) disable iff (rst)
    (ack && ready && win_vld && !aeoi && !wr_en) |=> isr[$past(win_idx)]);

  p_ack_drops_int_r8: assert property (@(posedge clk) disable iff (rst)
    (ack && ready) |=> !int_out);

  p_aeoi_keeps_isr_r9: assert property (@(posedge clk) disable iff (rst)
    (ack && ready && aeoi && !wr_en) |=> $stable(isr));

  p_named_eoi_r11: assert property (@(posedge clk) disable iff (rst)
    (wr_en && !addr && wdata[7:5] == 3'b011 && !wdata[4] && !wdata[3] && !ack)
      |=> !isr[$past(wdata[IDW-1:0])]);

  p_spurious_r13: assert property (@(posedge clk) disable iff (rst)
    (ack && ready && !win_vld && !wr_en) |=> ($stable(isr) && rdata[IDW-1:0] == '1));
endmodule

bind prog_irq_ctrl pic_chk #(.N_IN(N_IN), .DW(DW)) u_chk (
  .clk(clk), .rst(rst), .wr_en(wr_en), .addr(addr), .wdata(wdata), .ack(ack),
  .irq_in(irq_in), .rdata(rdata), .int_out(int_out), .isr(isr_q), .irr(irr_q),
  .mask(mask_q), .ready(ready_q), .aeoi(aeoi_q), .win_vld(win_vld),
  .win_idx(win_idx), .base(base_q)
);

// File: tb/prog_irq_ctrl_tb_top.sv
module prog_irq_ctrl_tb_top;
  logic clk = 1'b0;
  logic rst = 1'b1;
  logic master_mode = 1'b1;
  logic [7:0] irq = '0;
  logic wr_en = 1'b0, rd_en = 1'b0, addr = 1'b0, ack = 1'b0;
  logic [7:0] wdata = '0;
  logic [7:0] rdata;
  logic int_out;
  logic [7:0] casc_map;
  logic [2:0] slave_id;

  int n_chk = 0;
  int n_bad = 0;
  bit done = 1'b0;

  always #2 clk = ~clk;

  prog_irq_ctrl dut_i (
    .clk(clk), .rst(rst), .master_mode(master_mode), .irq_in(irq),
    .wr_en(wr_en), .rd_en(rd_en), .addr(addr), .wdata(wdata), .ack(ack),
    .rdata(rdata), .int_out(int_out), .casc_map(casc_map), .slave_id(slave_id)
  );

  task automatic chk(input string req, input int act, input int exp);
    n_chk++;
    if (act != exp) begin
      n_bad++;
      $display("FAIL %s: actual 0x%0h expected 0x%0h", req, act, exp);
    end
  endtask

  task automatic cyc(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic wr(input logic a, input logic [7:0] d);
    @(negedge clk);
    wr_en = 1'b1; addr = a; wdata = d;
    @(negedge clk);
    wr_en = 1'b0;
  endtask

  task automatic rd(input logic a, output logic [7:0] v);
    @(negedge clk);
    rd_en = 1'b1; addr = a;
    @(negedge clk);
    rd_en = 1'b0;
    v = rdata;
  endtask

  task automatic do_ack(output logic [7:0] v);
    @(negedge clk);
    ack = 1'b1;
    @(negedge clk);
    ack = 1'b0;
    v = rdata;
  endtask

  task automatic t_reset;
    logic [7:0] v;
    chk("R1 rdata", rdata, 0);
    chk("R1 int_out", int_out, 0);
    chk("R1 casc_map", casc_map, 0);
    chk("R1 slave_id", slave_id, 0);
    rd(1'b1, v); chk("R1 mask", v, 0);
    rd(1'b0, v); chk("R1 irr", v, 0);
    irq[0] = 1'b1; cyc(3);
    chk("R2 no int before setup", int_out, 0);
    do_ack(v); chk("R2 ack ignored before setup", v, 0);
    rd(1'b0, v); chk("R6 edge sets irr", v, 8'h01);
    irq[0] = 1'b0; cyc(1);
  endtask

  task automatic t_setup_master;
    master_mode = 1'b1;
    wr(1'b0, 8'h11); wr(1'b1, 8'h20);
    chk("R2 int low mid-sequence", int_out, 0);
    wr(1'b1, 8'h04); wr(1'b1, 8'h01); cyc(1);
    chk("R4 master casc_map", casc_map, 8'h04);
    chk("R4 master slave_id", slave_id, 0);
  endtask

  task automatic t_basic;
    logic [7:0] v;
    irq[3] = 1'b1; cyc(2);
    chk("R7 int raised", int_out, 1);
    do_ack(v);
    chk("R3 vector input 3", v, 8'h23);
    chk("R8 int low after ack", int_out, 0);
    wr(1'b0, 8'h0B); rd(1'b0, v); chk("R10 isr read", v, 8'h08);
    wr(1'b0, 8'h0A); rd(1'b0, v); chk("R10 irr read", v, 8'h00);
    wr(1'b0, 8'h65); wr(1'b0, 8'h0B); rd(1'b0, v);
    chk("R11 other level untouched", v, 8'h08);
    wr(1'b0, 8'h63); rd(1'b0, v); chk("R11 named level cleared", v, 8'h00);
    wr(1'b0, 8'h0A);
    irq[3] = 1'b0; cyc(1);
  endtask

  task automatic t_priority;
    logic [7:0] v;
    irq[5] = 1'b1; irq[1] = 1'b1; cyc(2);
    do_ack(v); chk("R7 lower index wins", v, 8'h21);
    cyc(2); chk("R7 lower level blocked", int_out, 0);
    rd(1'b0, v); chk("R7 blocked request kept", v, 8'h20);
    irq[0] = 1'b1; cyc(2);
    chk("R7 higher level nests", int_out, 1);
    do_ack(v); chk("R8 nested vector", v, 8'h20);
    wr(1'b0, 8'h0B); rd(1'b0, v); chk("R8 two levels in service", v, 8'h03);
    wr(1'b0, 8'h20); rd(1'b0, v); chk("R12 highest cleared", v, 8'h02);
    wr(1'b0, 8'h20); rd(1'b0, v); chk("R12 next cleared", v, 8'h00);
    cyc(1); chk("R7 unblocked request", int_out, 1);
    do_ack(v); chk("R3 vector input 5", v, 8'h25);
    wr(1'b0, 8'h65); wr(1'b0, 8'h0A);
    irq[0] = 1'b0; irq[1] = 1'b0; irq[5] = 1'b0; cyc(1);
  endtask

  task automatic t_mask;
    logic [7:0] v;
    wr(1'b1, 8'h10); rd(1'b1, v); chk("R5 mask readback", v, 8'h10);
    irq[4] = 1'b1; cyc(3);
    chk("R5 masked no int", int_out, 0);
    rd(1'b0, v); chk("R6 masked still requested", v, 8'h10);
    wr(1'b1, 8'h00); cyc(2);
    chk("R5 unmask raises int", int_out, 1);
    do_ack(v); chk("R3 vector input 4", v, 8'h24);
    wr(1'b0, 8'h64);
    irq[4] = 1'b0; cyc(1);
  endtask

  task automatic t_edge;
    logic [7:0] v;
    irq[2] = 1'b1; cyc(2);
    do_ack(v); chk("R3 vector input 2", v, 8'h22);
    wr(1'b0, 8'h62); cyc(3);
    chk("R6 held line no re-request", int_out, 0);
    rd(1'b0, v); chk("R6 irr clear while held", v, 8'h00);
    irq[2] = 1'b0; cyc(1); irq[2] = 1'b1; cyc(2);
    chk("R6 new edge requests", int_out, 1);
    do_ack(v); wr(1'b0, 8'h62);
    irq[2] = 1'b0; cyc(1);
  endtask

  task automatic t_spurious;
    logic [7:0] v;
    wr(1'b1, 8'h80);
    irq[6] = 1'b1; cyc(2);
    chk("R7 int for input 6", int_out, 1);
    irq[6] = 1'b0; cyc(1);
    do_ack(v); chk("R13 spurious vector", v, 8'h27);
    wr(1'b0, 8'h0B); rd(1'b0, v); chk("R13 isr untouched", v, 8'h00);
    wr(1'b0, 8'h0A); wr(1'b1, 8'h00);
  endtask

  task automatic t_slave_aeoi;
    logic [7:0] v;
    wr(1'b1, 8'h55);
    master_mode = 1'b0;
    wr(1'b0, 8'h11);
    rd(1'b1, v); chk("R2 start clears mask", v, 8'h00);
    wr(1'b1, 8'h28); wr(1'b1, 8'h02); wr(1'b1, 8'h03); cyc(1);
    chk("R4 slave id", slave_id, 2);
    chk("R4 slave casc_map", casc_map, 0);
    irq[1] = 1'b1; cyc(2);
    do_ack(v); chk("R3 slave vector", v, 8'h29);
    wr(1'b0, 8'h0B); rd(1'b0, v); chk("R9 auto-clear isr", v, 8'h00);
    wr(1'b0, 8'h0A);
    irq[1] = 1'b0; cyc(1);
  endtask

  task automatic t_single;
    logic [7:0] v;
    master_mode = 1'b1;
    wr(1'b0, 8'h12); wr(1'b1, 8'h40); cyc(1);
    chk("R4 single casc_map", casc_map, 0);
    irq[7] = 1'b1; cyc(2);
    chk("R2 ready after two words", int_out, 1);
    do_ack(v); chk("R3 vector base 0x40", v, 8'h47);
    wr(1'b0, 8'h0B); rd(1'b0, v); chk("R8 isr set without word 4", v, 8'h80);
    wr(1'b1, 8'h80); rd(1'b1, v); chk("R5 third write is mask", v, 8'h80);
    wr(1'b0, 8'h67);
    irq[7] = 1'b0; cyc(1);
  endtask

  initial begin
    cyc(3);
    chk("R1 rdata in reset", rdata, 0);
    rst = 1'b0;
    cyc(1);
    t_reset();
    t_setup_master();
    t_basic();
    t_priority();
    t_mask();
    t_edge();
    t_spurious();
    t_slave_aeoi();
    t_single();
    done = 1'b1;
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
    $finish;
  end

  initial begin
    repeat (20000) @(posedge clk);
    if (!done) begin
      n_chk++;
      n_bad++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
      $finish;
    end
  end
endmodule